// File: doc/BRIEF.md
# Recursive Binary-to-One-Hot Decoder

This block turns an unsigned binary code of a configurable width into a one-hot vector with one line per code value. It is purely combinational. A typical use is row or bank selection, where one of many targets must be picked from a compact index.

Internally the code is cut into a lower and an upper field. Each field is decoded by a smaller copy of the same tree. A rectangular grid of two-input AND gates then pairs every upper-field line with every lower-field line. The lower field holds half the bits, rounded down. Each level of the tree therefore halves the width, which keeps the gate depth logarithmic in the code width. A one-bit field is decoded by a single inverter. A gate input at the top can force the whole output vector to zero.

Top module: `onehot_decoder`

## Requirements
- R1: With `en` high, `sel[i]` is 1 exactly when the unsigned value of `code` equals i, and every other bit of `sel` is 0.
- R2: For a code width of 1, `sel[0]` is the inverse of the code bit and `sel[1]` equals the code bit.
- R3: For width W ≥ 2, the low floor(W/2) code bits and the high W − floor(W/2) code bits are decoded separately by smaller copies of the tree.
- R4: Output index u·2^L + l, where L = floor(W/2), is the AND of upper-field line u and lower-field line l. All 2^(W−L) × 2^L pairs are formed, and for every code value exactly one pair is active.
- R5: With `en` low, every bit of `sel` is 0, whatever the value of `code`.
- R6: With a 3-bit code of binary 101 and `en` high, only `sel[5]` is 1, so `sel` reads 00100000 from the top bit down.
- R7: The code width `CODE_W` is a parameter of value 1 or more, and `sel` is 2^`CODE_W` bits wide. A width below 1 is rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| en | input | 1 | Output gate; when low, all select lines are 0 |
| code | input | CODE_W | Unsigned binary index to decode |
| sel | output | 2**CODE_W | One-hot select vector; bit i is high for code i |

## Verification
No register lies between `code`/`en` and `sel`, so every result is due in the same cycle as its stimulus. The driver changes the inputs just after a rising clock edge and queues the expected vector at that moment. The monitor samples `sel` on the following falling edge and compares it against the head of the queue, so each comparison sees inputs that settled half a period earlier. Every code value is swept, with the gate both low and high, for each width from 1 to 8, on separate instances running side by side.

// File: rtl/onehot_dec_pkg.sv
package onehot_dec_pkg;
   // Width handled by the lower sub-tree at a node of width w.
   function automatic int low_split(input int w);
      return w / 2;
   endfunction
   // Width handled by the upper sub-tree at a node of width w.
   function automatic int high_split(input int w);
      return w - (w / 2);
   endfunction
endpackage

// File: rtl/onehot_dec_leaf.sv
module onehot_dec_leaf (
   input  logic       bit_in,
   output logic [1:0] lines
);
   assign lines[0] = ~bit_in;
   assign lines[1] = bit_in;

   always_comb begin
      assert_leaf_complement_R2: assert (lines[0] != lines[1])
         else $error("leaf lines not complementary");
   end
endmodule

// File: rtl/onehot_cross_and.sv
module onehot_cross_and #(
   parameter int ROWS = 2,
   parameter int COLS = 2
) (
   input  logic [ROWS-1:0]      row_sel,
   input  logic [COLS-1:0]      col_sel,
   output logic [ROWS*COLS-1:0] grid
);
   initial begin
      if (ROWS < 2 || COLS < 2) $error("cross array needs at least 2x2");
   end

   for (genvar u = 0; u < ROWS; u++) begin : g_row
      for (genvar l = 0; l < COLS; l++) begin : g_col
         assign grid[u*COLS + l] = row_sel[u] & col_sel[l];
      end
   end

   always_comb begin
      if ($onehot(row_sel) && $onehot(col_sel)) begin
         assert_grid_single_R4: assert ($onehot(grid))
            else $error("grid not one-hot for one-hot operands");
      end
   end
endmodule

// File: rtl/onehot_dec_tree.sv
module onehot_dec_tree #(
   parameter int W = 3
) (
   input  logic [W-1:0]      idx,
   output logic [(1<<W)-1:0] lines
);
   import onehot_dec_pkg::*;

   localparam int LW = low_split(W);
   localparam int HW = high_split(W);

   if (W < 1) begin : g_bad
      initial $error("tree width must be at least 1");
   end else if (W == 1) begin : g_leaf
      onehot_dec_leaf u_leaf (
         .bit_in (idx[0]),
         .lines  (lines)
      );
   end else begin : g_split
      logic [(1<<LW)-1:0] low_lines;
      logic [(1<<HW)-1:0] high_lines;

      // R3: lower and upper fields decoded by smaller trees
      onehot_dec_tree #(.W(LW)) u_low (
         .idx   (idx[LW-1:0]),
         .lines (low_lines)
      );
      onehot_dec_tree #(.W(HW)) u_high (
         .idx   (idx[W-1:LW]),
         .lines (high_lines)
      );

      onehot_cross_and #(.ROWS(1<<HW), .COLS(1<<LW)) u_grid (
         .row_sel (high_lines),
         .col_sel (low_lines),
         .grid    (lines)
      );

      always_comb begin
         assert_low_field_R3: assert (low_lines[idx[LW-1:0]])
            else $error("lower sub-tree line mismatch");
         assert_high_field_R3: assert (high_lines[idx[W-1:LW]])
            else $error("upper sub-tree line mismatch");
      end
   end
endmodule

// File: rtl/onehot_decoder.sv
module onehot_decoder #(
   parameter int CODE_W = 3
) (
   input  logic                   en,
   input  logic [CODE_W-1:0]      code,
   output logic [(1<<CODE_W)-1:0] sel
);
   localparam int N_OUT = 1 << CODE_W;

   initial begin
      assert_width_legal_R7: assert (CODE_W >= 1)
         else $error("CODE_W must be 1 or more");
   end

   logic [N_OUT-1:0] raw;

   onehot_dec_tree #(.W(CODE_W)) u_tree (
      .idx   (code),
      .lines (raw)
   );

   assign sel = raw & {N_OUT{en}};

   always_comb begin
      if (!en) begin
         assert_gate_off_R5: assert (sel == '0)
            else $error("select active while gated off");
      end else begin
         assert_hit_index_R1: assert ($onehot(sel) && sel[code])
            else $error("select not one-hot at code");
      end
   end
endmodule

// File: tb/tb_onehot_decoder.sv
module tb_onehot_decoder;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   int         total = 0;
   int         bad = 0;
   logic [8:1] fin;

   always #5 clk = ~clk;

   task automatic chk(input bit ok, input string req,
                      input logic [255:0] act, input logic [255:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   for (genvar gi = 1; gi <= 8; gi++) begin : g_w
      localparam int W = gi;
      localparam int N = 1 << W;
      logic [W-1:0]   code;
      logic           en;
      logic [N-1:0]   sel;
      logic [N-1:0]   exp_q[$];
      string          tag_q[$];
      logic           done_l = 1'b0;

      assign fin[gi] = done_l;

      onehot_decoder #(.CODE_W(W)) dut (
         .en   (en),
         .code (code),
         .sel  (sel)
      );

      // driver
      initial begin
         code = '0;
         en   = 1'b0;
         @(negedge clk);
         chk(sel == '0, "R5 reset state", 256'(sel), 256'(0));
         chk($bits(sel) == N, "R7 output width", 256'($bits(sel)), 256'(N));
         @(posedge rst_n);
         for (int e = 0; e < 2; e++) begin
            for (int v = 0; v < N; v++) begin
               @(posedge clk);
               #1;
               code = v[W-1:0];
               en   = e[0];
               exp_q.push_back(e[0] ? (N'(1) << v) : N'(0));
               if (W == 1)                          tag_q.push_back("R2");
               else if (W == 3 && v == 5 && e == 1) tag_q.push_back("R6");
               else if (e == 0)                     tag_q.push_back("R5");
               else                                 tag_q.push_back("R1/R3/R4");
            end
         end
         @(posedge clk);
         @(posedge clk);
         done_l = 1'b1;
      end

      // monitor: result due in the same cycle, sampled at falling edge
      always @(negedge clk) begin
         if (exp_q.size() > 0) begin
            logic [N-1:0] e_v;
            string        t_v;
            e_v = exp_q.pop_front();
            t_v = tag_q.pop_front();
            chk(sel === e_v, t_v, 256'(sel), 256'(e_v));
         end
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      fork
         begin
            wait (&fin);
         end
         begin
            repeat (5000) @(posedge clk);
            chk(1'b0, "watchdog", 256'(fin), 256'hff);
         end
      join_any
      disable fork;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule